// File: doc/BRIEF.md
# Phase-Accumulator Tone Oscillator

This block is one voice of a tone generator. A 24-bit phase accumulator advances by a 16-bit step on every enabled clock and wraps around, so the step sets the pitch. The upper accumulator bits are shaped into one of three 12-bit waveforms: a rising ramp, a folded ramp (triangle) or a rectangular wave whose duty cycle comes from a 12-bit threshold. An 8-bit readback carries the top bits of the waveform so that a host can sample the oscillator as a modulation source.

The step, threshold and mode byte are loaded through a byte-wide write port. The mode byte selects the waveform and carries three flags. The test flag zeroes and freezes the accumulator and forces the rectangular wave high. The ring flag lets a second voice's top bit flip the triangle fold. The sync flag is passed out to the neighbouring sync logic. For use by other voices the block exports its accumulator top bit and a one-cycle flag that marks its rising edge. It accepts a clear strobe from the sync logic that restarts the phase. Waveform codes that would need lookup tables, and the noise code, produce zero here.

Top module: `tone_osc`

## Requirements
- R1: On each clock with `en` high (and no clear or test), the accumulator becomes (accumulator + step) modulo 2^24. With `en` low it holds its value.
- R2: Writes with `wr_en` high store `wr_data` by `wr_addr`: 0 = step bits 7:0, 1 = step bits 15:8, 2 = threshold bits 7:0, 3 = threshold bits 11:8 (only `wr_data[3:0]` is kept, the upper four bits are dropped), 4 = mode byte. Mode byte bits: 1 = sync, 2 = ring, 3 = test, 7:4 = waveform code.
- R3: A mode write with bit 3 set zeroes the accumulator at the clock edge that stores it. While test is set the accumulator stays zero whatever `en` does. After test is cleared, counting resumes from zero.
- R4: With waveform code 2, `wave_out` equals accumulator bits 23:12.
- R5: With waveform code 4, `wave_out` is 0xFFF when accumulator bits 23:12 are greater than or equal to the threshold, and 0x000 otherwise. While test is set it is 0xFFF.
- R6: With waveform code 1, `wave_out` is accumulator bits 22:11, with every bit inverted when the fold bit is 1. The fold bit is accumulator bit 23. With ring set, it is bit 23 XOR `mod_msb`.
- R7: Waveform codes 0, 3, 5, 6, 7 and 8 through 15 give `wave_out` = 0.
- R8: `clr_strobe` high at a clock edge loads the accumulator with zero, taking priority over the addition.
- R9: `acc_msb` equals accumulator bit 23. `msb_rise` is high for exactly the one cycle after the clock edge at which bit 23 went from 0 to 1.
- R10: `osc_read` equals `wave_out` shifted right by 4.
- R11: Synchronous reset clears the step, the threshold, the mode byte and the accumulator. All outputs are then zero.
- R12: `sync_mode` reflects mode byte bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Accumulator advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write data byte |
| clr_strobe | input | 1 | Accumulator clear from the sync logic |
| mod_msb | input | 1 | Top accumulator bit of the modulating voice |
| wave_out | output | 12 | Selected waveform sample |
| osc_read | output | 8 | Upper eight waveform bits |
| acc_msb | output | 1 | Accumulator bit 23 |
| msb_rise | output | 1 | Bit 23 rose at the last clock edge |
| sync_mode | output | 1 | Sync flag from the mode byte |

## Verification
A table of step, threshold, mode and run length is walked from reset. The expected sample is modelled from the accumulated phase. Ramp runs of different lengths include one that wraps past 2^24, which tells a true modulo wrap apart from saturation. Rectangular runs place the ramp below, above and exactly at the threshold, which shows whether the comparison is greater-or-equal or strictly greater. Triangle runs with the top bit clear and set, with the modulating bit at both levels, show the fold and its ring substitution. Directed cases cover the masked threshold high byte, test freezing and forcing, the priority of the clear strobe over the addition, and the one-cycle timing of the rising flag.

// File: rtl/tone_osc.sv
module tone_osc #(
  parameter int ACC_W = 24,
  parameter int OUT_W = 12,
  parameter int RD_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             clr_strobe,
  input  logic             mod_msb,
  output logic [OUT_W-1:0] wave_out,
  output logic [RD_W-1:0]  osc_read,
  output logic             acc_msb,
  output logic             msb_rise,
  output logic             sync_mode
);

  localparam int MSB = ACC_W - 1;
  localparam logic [2:0] A_FLO = 3'd0, A_FHI = 3'd1, A_PLO = 3'd2, A_PHI = 3'd3, A_CTL = 3'd4;
  localparam logic [3:0] W_TRI = 4'd1, W_SAW = 4'd2, W_PUL = 4'd4;

  logic [15:0]      freq_q;
  logic [11:0]      pw_q;
  logic [3:0]       wave_sel;
  logic             sync_q, ring_q, test_q;
  logic [ACC_W-1:0] acc_q;

  logic             ctl_wr, test_next, fold;
  logic [ACC_W-1:0] acc_sum;
  logic [OUT_W-1:0] saw, tri_w, pulse;
  logic             unused_bit;

  assign unused_bit = wr_data[0];
  assign ctl_wr     = wr_en && (wr_addr == A_CTL);
  assign test_next  = ctl_wr ? wr_data[3] : test_q;
  assign acc_sum    = acc_q + ACC_W'(freq_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q   <= '0;
      pw_q     <= '0;
      wave_sel <= '0;
      sync_q   <= 1'b0;
      ring_q   <= 1'b0;
      test_q   <= 1'b0;
      acc_q    <= '0;
      msb_rise <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_FLO: freq_q[7:0]  <= wr_data;
          A_FHI: freq_q[15:8] <= wr_data;
          A_PLO: pw_q[7:0]    <= wr_data;
          A_PHI: pw_q[11:8]   <= wr_data[3:0];
          A_CTL: begin
            wave_sel <= wr_data[7:4];
            test_q   <= wr_data[3];
            ring_q   <= wr_data[2];
            sync_q   <= wr_data[1];
          end
          default: ;
        endcase
      end
      if (clr_strobe || test_next) begin
        acc_q    <= '0;
        msb_rise <= 1'b0;
      end else if (en) begin
        acc_q    <= acc_sum;
        msb_rise <= !acc_q[MSB] && acc_sum[MSB];
      end else begin
        msb_rise <= 1'b0;
      end
    end
  end

  assign saw   = acc_q[MSB -: OUT_W];
  assign fold  = ring_q ? (acc_q[MSB] ^ mod_msb) : acc_q[MSB];
  assign tri_w = fold ? ~acc_q[MSB-1 -: OUT_W] : acc_q[MSB-1 -: OUT_W];
  assign pulse = (test_q || (saw >= pw_q)) ? '1 : '0;

  always_comb begin
    case (wave_sel)
      W_TRI:   wave_out = tri_w;
      W_SAW:   wave_out = saw;
      W_PUL:   wave_out = pulse;
      default: wave_out = '0;
    endcase
  end

  assign osc_read  = wave_out[OUT_W-1 -: RD_W];
  assign acc_msb   = acc_q[MSB];
  assign sync_mode = sync_q;

endmodule

// File: rtl/tone_osc_chk.sv
module tone_osc_chk (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic        clr_strobe,
  input logic [23:0] acc,
  input logic [15:0] freq,
  input logic        test,
  input logic [3:0]  sel,
  input logic [11:0] wave_out,
  input logic        msb_rise
);

  logic wr_test;
  assign wr_test = wr_en && (wr_addr == 3'd4) && wr_data[3];

  assert_acc_step_R1: assert property (@(posedge clk) disable iff (rst)
    (en && !clr_strobe && !test && !wr_test) |=> (acc == $past(acc + {8'h00, freq})));

  assert_acc_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr_strobe && !test && !wr_test) |=> $stable(acc));

  assert_test_zero_R3: assert property (@(posedge clk) disable iff (rst)
    test |-> (acc == 24'h0));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_strobe |=> (acc == 24'h0));

  assert_rise_edge_R9: assert property (@(posedge clk) disable iff (rst)
    msb_rise |-> (acc[23] && !$past(acc[23])));

  assert_pulse_forced_R5: assert property (@(posedge clk) disable iff (rst)
    (test && sel == 4'd4) |-> (wave_out == 12'hFFF));

  assert_other_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (sel != 4'd1 && sel != 4'd2 && sel != 4'd4) |-> (wave_out == 12'h000));

endmodule

bind tone_osc tone_osc_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .clr_strobe(clr_strobe), .acc(acc_q), .freq(freq_q),
  .test(test_q), .sel(wave_sel), .wave_out(wave_out), .msb_rise(msb_rise)
);

// File: tb/sim_tone_osc.sv
`timescale 1ns/1ps
module sim_tone_osc;
  logic clk = 1'b0, rst = 1'b1, en = 1'b0, wr_en = 1'b0, clr_strobe = 1'b0, mod_msb = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [11:0] wave_out;
  logic [7:0]  osc_read;
  logic acc_msb, msb_rise, sync_mode;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tone_osc u0 (.clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clr_strobe(clr_strobe), .mod_msb(mod_msb), .wave_out(wave_out),
    .osc_read(osc_read), .acc_msb(acc_msb), .msb_rise(msb_rise), .sync_mode(sync_mode));

  // {step, threshold, mode, mod_msb, cycles}
  localparam logic [52:0] VEC [14] = '{
    {16'h1234, 12'h000, 8'h20, 1'b0, 16'd100},
    {16'hFFFF, 12'h000, 8'h20, 1'b0, 16'd257},
    {16'h4000, 12'h800, 8'h40, 1'b0, 16'd300},
    {16'h4000, 12'h400, 8'h40, 1'b0, 16'd300},
    {16'h4000, 12'h4B0, 8'h40, 1'b0, 16'd300},
    {16'h4000, 12'h4B1, 8'h40, 1'b0, 16'd300},
    {16'h9000, 12'h000, 8'h10, 1'b0, 16'd200},
    {16'hF000, 12'h000, 8'h10, 1'b0, 16'd200},
    {16'hF000, 12'h000, 8'h14, 1'b1, 16'd200},
    {16'h9000, 12'h000, 8'h14, 1'b1, 16'd200},
    {16'h3000, 12'h000, 8'h80, 1'b0, 16'd50},
    {16'h3000, 12'h000, 8'h30, 1'b0, 16'd50},
    {16'h3000, 12'h000, 8'hF0, 1'b0, 16'd50},
    {16'h3000, 12'h000, 8'h00, 1'b0, 16'd50}
  };

  function automatic logic [11:0] model(logic [23:0] a, logic [7:0] m, logic [11:0] pw, logic mb);
    logic f;
    f = m[2] ? (a[23] ^ mb) : a[23];
    case (m[7:4])
      4'd1:    return f ? ~a[22:11] : a[22:11];
      4'd2:    return a[23:12];
      4'd4:    return (m[3] || a[23:12] >= pw) ? 12'hFFF : 12'h000;
      default: return 12'h000;
    endcase
  endfunction

  function automatic string tag(logic [3:0] c);
    case (c)
      4'd1: return "R6";
      4'd2: return "R4";
      4'd4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    en = 1'b1;
    repeat (n) @(negedge clk);
    en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R11 wave", 24'(wave_out), 24'h0);
    chk("R11 read", 24'(osc_read), 24'h0);
    chk("R11 flags", {21'h0, acc_msb, msb_rise, sync_mode}, 24'h0);

    for (int i = 0; i < 14; i++) begin
      logic [15:0] f; logic [11:0] pw; logic [7:0] m; logic mb; logic [15:0] n;
      logic [23:0] a; logic [11:0] e;
      {f, pw, m, mb, n} = VEC[i];
      do_reset();
      wr(3'd0, f[7:0]); wr(3'd1, f[15:8]);
      wr(3'd2, pw[7:0]); wr(3'd3, {4'h0, pw[11:8]});
      wr(3'd4, m);
      mod_msb = mb;
      run(int'(n));
      a = 24'(32'(f) * 32'(n));
      e = model(a, m, pw, mb);
      chk($sformatf("%s vec %0d", tag(m[7:4]), i), 24'(wave_out), 24'(e));
      chk($sformatf("R10 vec %0d", i), 24'(osc_read), 24'(e[11:4]));
      chk($sformatf("R9 msb vec %0d", i), 24'(acc_msb), 24'(a[23]));
    end
    mod_msb = 1'b0;

    // R1 hold with en low
    do_reset();
    wr(3'd0, 8'h00); wr(3'd1, 8'h10); wr(3'd4, 8'h20);
    run(20);
    chk("R1 advance", 24'(wave_out), 24'h014);
    repeat (10) @(negedge clk);
    chk("R1 hold en low", 24'(wave_out), 24'h014);

    // R8 clear wins over add
    en = 1'b1; clr_strobe = 1'b1;
    @(negedge clk);
    en = 1'b0; clr_strobe = 1'b0;
    chk("R8 clear", 24'(wave_out), 24'h000);
    run(1);
    chk("R8 resume", 24'(wave_out), 24'h001);

    // R2 threshold high byte masked: 0xF0 must store 0x0
    do_reset();
    wr(3'd2, 8'h00); wr(3'd3, 8'hF0); wr(3'd4, 8'h40);
    chk("R2 pw hi mask", 24'(wave_out), 24'hFFF);

    // R3 test freezes and forces pulse
    do_reset();
    wr(3'd0, 8'h00); wr(3'd1, 8'h10); wr(3'd2, 8'hFF); wr(3'd3, 8'h0F);
    wr(3'd4, 8'h20);
    run(50);
    chk("R4 before test", 24'(wave_out), 24'h032);
    wr(3'd4, 8'h48);
    chk("R5 test forces pulse", 24'(wave_out), 24'hFFF);
    wr(3'd4, 8'h28);
    run(10);
    chk("R3 test holds zero", 24'(wave_out), 24'h000);
    wr(3'd4, 8'h20);
    run(3);
    chk("R3 resume after test", 24'(wave_out), 24'h003);

    // R9 rising flag timing with step 0xFFFF: bit 23 rises on edge 129
    do_reset();
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd4, 8'h00);
    run(128);
    chk("R9 before rise", {22'h0, acc_msb, msb_rise}, 24'h0);
    run(1);
    chk("R9 rise", {22'h0, acc_msb, msb_rise}, 24'h3);
    @(negedge clk);
    chk("R9 one cycle", {22'h0, acc_msb, msb_rise}, 24'h2);

    // R12 sync flag
    wr(3'd4, 8'h02);
    chk("R12 sync set", 24'(sync_mode), 24'h1);
    chk("R7 code 0", 24'(wave_out), 24'h0);

    // R11 reset mid-run clears step and mode
    do_reset();
    chk("R11 sync cleared", 24'(sync_mode), 24'h0);
    wr(3'd4, 8'h20);
    run(5);
    chk("R11 step cleared", 24'(wave_out), 24'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule